// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses for one burst of an SDRAM read or write. A start strobe loads a 10-bit starting column, a 3-bit burst-length code and an ordering bit. From the next cycle on, the block presents one column per beat. Each beat carries a valid flag and a last-beat flag. A burst of fixed length stays inside an aligned block whose size is the burst length. A full-page burst walks the whole 1024-column page and runs until a terminate input stops it.

The column output is a valid/ready stream. A beat is consumed only in a cycle where `col_valid_o` and `col_ready_i` are both high. While `col_ready_i` is low the current beat is held: the address does not change and the burst position does not move. The start strobe is a plain control input. It takes effect whatever `col_ready_i` is, and it aborts any burst in flight. The terminate strobe is also a plain input. It is honoured only on a beat that is being consumed. Command encoding, bank and row selection, latency and data are left to the surrounding controller.

Top module: `burst_colgen`

## Requirements
- R1: After reset, `col_valid_o`, `col_last_o` and `len_err_o` are low until a start strobe is seen.
- R2: The cycle after `start_i` is high, `col_valid_o` is high and `col_addr_o` equals the `start_col_i` value sampled with the strobe.
- R3: The length code is decoded as 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8 and 111 = full page. A fixed-length burst presents exactly that many consumed beats. After its last beat is consumed, `col_valid_o` drops, unless a new start arrives.
- R4: With the ordering bit low (sequential), the low log2(L) bits of each new beat are the previous low bits plus one, modulo L. The column bits above them never change during the burst.
- R5: With the ordering bit high (interleaved), the low bits of beat n are the starting low bits XOR n. The upper bits are held as in R4.
- R6: A full-page burst counts up through all column bits and wraps from 1023 to 0. It never ends on its own, and it is always sequential: the ordering bit is ignored.
- R7: `col_last_o` is high on the final beat of a fixed-length burst. It is also high on any valid beat while `term_i` is high. A consumed beat with `col_last_o` high ends the burst.
- R8: Codes 100, 101 and 110 are reserved. They run a 1-beat burst, and `len_err_o` is high while that beat is valid.
- R9: While `col_valid_o` is high and `col_ready_i` is low, with no start, the address is held and the burst position does not advance.
- R10: A start strobe during an active burst drops the rest of that burst. The new burst's first column appears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst (aborts any current one) |
| start_col_i | input | 10 | Starting column, sampled with start_i |
| len_code_i | input | 3 | Burst-length code, sampled with start_i |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential; sampled with start_i |
| term_i | input | 1 | Terminate the burst on the current beat |
| col_ready_i | input | 1 | Consumer accepts the current beat |
| col_valid_o | output | 1 | A column beat is presented |
| col_addr_o | output | 10 | Column address of the current beat |
| col_last_o | output | 1 | Current beat is the final one |
| len_err_o | output | 1 | Current burst was started with a reserved length code |

## Verification
The assertions check the following on every cycle: the load of the starting column, holding under back-pressure, the fixed upper column bits, the plus-one step of sequential bursts, the drop of valid after a consumed last beat, and the absence of a self-generated last in full-page bursts. The exact beat orders need the bench's behavioural model, compared on every clock. These include the XOR order of interleaved bursts, the wrap from 1023 to 0, burst counts per length code, reserved-code handling, and aborts at chosen beats.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;
  localparam int COL_W    = 10;
  localparam int LEN_W    = 3;
  localparam int MAX_LOG2 = 3;   // largest fixed burst is 2**MAX_LOG2 beats

  typedef enum logic [LEN_W-1:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
  parameter int COL_W    = burst_colgen_pkg::COL_W,
  parameter int LEN_W    = burst_colgen_pkg::LEN_W,
  parameter int MAX_LOG2 = burst_colgen_pkg::MAX_LOG2
) (
  input  logic [LEN_W-1:0] code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             rsvd_o
);
  localparam int NCODE     = 1 << LEN_W;
  localparam int PAGE_CODE = NCODE - 1;

  logic [COL_W-1:0] mask_tab [NCODE];
  logic [NCODE-1:0] page_tab;
  logic [NCODE-1:0] rsvd_tab;

  // one table entry per code: full page, a power-of-two block, or reserved
  for (genvar k = 0; k < NCODE; k++) begin : g_code
    if (k == PAGE_CODE) begin : g_page
      assign mask_tab[k] = '1;
      assign page_tab[k] = 1'b1;
      assign rsvd_tab[k] = 1'b0;
    end else if (k <= MAX_LOG2) begin : g_fixed
      assign mask_tab[k] = COL_W'((1 << k) - 1);
      assign page_tab[k] = 1'b0;
      assign rsvd_tab[k] = 1'b0;
    end else begin : g_rsvd
      assign mask_tab[k] = '0;
      assign page_tab[k] = 1'b0;
      assign rsvd_tab[k] = 1'b1;
    end
  end

  assign mask_o = mask_tab[code_i];
  assign page_o = page_tab[code_i];
  assign rsvd_o = rsvd_tab[code_i];
endmodule

// File: rtl/colgen_addr_gen.sv
module colgen_addr_gen #(
  parameter int COL_W = burst_colgen_pkg::COL_W
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_ilv;

  assign low_seq = base_i + beat_i;
  assign low_ilv = base_i ^ beat_i;

  // bits above the mask come from the start column; bits inside it are stepped
  assign addr_o = (base_i & ~mask_i) | ((ilv_i ? low_ilv : low_seq) & mask_i);
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int COL_W    = burst_colgen_pkg::COL_W,
  parameter int LEN_W    = burst_colgen_pkg::LEN_W,
  parameter int MAX_LOG2 = burst_colgen_pkg::MAX_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             ilv_i,
  input  logic             term_i,
  input  logic             col_ready_i,
  output logic             col_valid_o,
  output logic [COL_W-1:0] col_addr_o,
  output logic             col_last_o,
  output logic             len_err_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page, dec_rsvd;

  logic             active_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             ilv_q, page_q, rsvd_q;
  logic             fire, end_beat;

  colgen_len_decode #(.COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG2(MAX_LOG2)) u_dec (
    .code_i (len_code_i),
    .mask_o (dec_mask),
    .page_o (dec_page),
    .rsvd_o (dec_rsvd)
  );

  colgen_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .beat_i (beat_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .addr_o (col_addr_o)
  );

  assign fire     = active_q & col_ready_i;
  assign end_beat = active_q & (term_i | (~page_q & (beat_q == mask_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
      ilv_q    <= 1'b0;
      page_q   <= 1'b0;
      rsvd_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      base_q   <= start_col_i;
      beat_q   <= '0;
      mask_q   <= dec_mask;
      ilv_q    <= ilv_i & ~dec_page;
      page_q   <= dec_page;
      rsvd_q   <= dec_rsvd;
    end else if (fire) begin
      if (end_beat) active_q <= 1'b0;
      else          beat_q   <= beat_q + 1'b1;
    end
  end

  assign col_valid_o = active_q;
  assign col_last_o  = end_beat;
  assign len_err_o   = active_q & rsvd_q;

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> col_valid_o && col_addr_o == $past(start_col_i));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && !col_ready_i && !start_i |=> col_valid_o && $stable(col_addr_o));
  // R4
  block_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && col_ready_i && !col_last_o && !start_i
      |=> ((col_addr_o ^ $past(col_addr_o)) & ~mask_q) == '0);
  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && col_ready_i && !col_last_o && !start_i && !ilv_q
      |=> ((col_addr_o - $past(col_addr_o)) & mask_q) == COL_W'(1));
  // R3
  end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && col_ready_i && col_last_o && !start_i |=> !col_valid_o);
  // R6
  page_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && page_q && !term_i |-> !col_last_o);
  // R8
  err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_o |-> col_valid_o && col_last_o);
endmodule

// File: tb/burst_colgen_tb.sv
module burst_colgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE       = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       term_i = 1'b0;
  logic       col_ready_i = 1'b0;
  logic       col_valid_o;
  logic [9:0] col_addr_o;
  logic       col_last_o;
  logic       len_err_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // behavioural reference state
  bit m_act, m_ilv, m_page, m_err, m_abort;
  int m_base, m_n, m_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_colgen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .term_i(term_i), .col_ready_i(col_ready_i),
    .col_valid_o(col_valid_o), .col_addr_o(col_addr_o), .col_last_o(col_last_o),
    .len_err_o(len_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_addr();
    int blk, low;
    blk = m_base - (m_base % m_len);
    low = m_base % m_len;
    if (m_ilv) return blk + (low ^ m_n);
    return blk + ((low + m_n) % m_len);
  endfunction

  // drive one cycle's inputs, compare, then advance the model past the edge
  task automatic cyc(input bit st, input int col, input int code, input bit il,
                     input bit tm, input bit rdy);
    bit e_last;
    string areq;
    start_i = st; start_col_i = 10'(col); len_code_i = 3'(code);
    ilv_i = il; term_i = tm; col_ready_i = rdy;
    #1;
    e_last = m_act && (tm || (!m_page && m_n == m_len - 1));
    chk("R3 valid", int'(col_valid_o), int'(m_act));
    if (m_act) begin
      if (m_abort && m_n == 0) areq = "R10 addr";
      else if (m_n == 0)       areq = "R2 addr";
      else if (m_page)         areq = "R6 addr";
      else if (m_ilv)          areq = "R5 addr";
      else                     areq = "R4 addr";
      chk(areq, int'(col_addr_o), exp_addr());
    end
    chk("R7 last", int'(col_last_o), int'(e_last));
    chk("R8 err", int'(len_err_o), int'(m_act && m_err));
    if (st) begin
      m_abort = m_act;
      m_act = 1; m_base = col; m_n = 0; m_err = 0; m_page = 0;
      if (code <= 3)      m_len = 1 << code;
      else if (code == 7) begin m_len = PAGE; m_page = 1; end
      else begin m_len = 1; m_err = 1; end
      m_ilv = il && !m_page;
    end else if (m_act && rdy) begin
      if (e_last) m_act = 0;
      else m_n = (m_n + 1) % PAGE;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1);
  endtask

  task automatic burst(input int col, input int code, input bit il, input int beats);
    cyc(1, col, code, il, 0, 1);
    for (int i = 0; i < beats; i++) cyc(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", int'(col_valid_o), 0);
    chk("R1 last", int'(col_last_o), 0);
    chk("R1 err", int'(len_err_o), 0);
    rst_n = 1'b1;
    idle(2);
    // R4: sequential length 4 from column 5 -> 5,6,7,4
    burst(10'h005, 2, 0, 5);
    // R5: interleaved length 8 starting at low bits 101
    burst(10'h3FD, 3, 1, 9);
    // R4: sequential length 8 wrapping within the block
    burst(10'h3FD, 3, 0, 9);
    // R3: lengths 2 and 1
    burst(10'h0A3, 1, 0, 3);
    burst(10'h0A3, 1, 1, 3);
    burst(10'h123, 0, 0, 2);
    // R8: reserved codes
    burst(10'h055, 4, 0, 2);
    burst(10'h056, 5, 1, 2);
    burst(10'h057, 6, 0, 2);
    // R6: full page wrapping past 1023, then terminate (R7)
    cyc(1, 1020, 7, 0, 0, 1);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 1);
    idle(2);
    // R6: ordering bit ignored on full page
    cyc(1, 10'h201, 7, 1, 0, 1);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0);   // terminate while stalled has no effect yet
    cyc(0, 0, 0, 0, 1, 1);
    idle(2);
    // R9: back-pressure inside a length-8 interleaved burst
    cyc(1, 10'h1C6, 3, 1, 0, 0);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 0, i % 3 == 0);
    idle(6);
    // R10: abort a burst mid-way with a new one
    cyc(1, 10'h010, 3, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 10'h2F2, 2, 1, 0, 0);
    idle(5);
    // R7: terminate during a fixed-length burst
    cyc(1, 10'h040, 3, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 1);
    idle(2);
    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      int r, code;
      r = int'($urandom_range(0, 99));
      code = int'($urandom_range(0, 7));
      cyc(r < 8, int'($urandom_range(0, 1023)), code, $urandom_range(0, 1) == 1,
          $urandom_range(0, 19) == 0, $urandom_range(0, 3) != 0);
    end
    idle(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule